// File: doc/BRIEF.md
# Programmable Buzzer Tone Generator

This peripheral produces a square-wave buzzer tone from a 12 or 13 MHz reference clock. The pitch comes from a cascade of dividers. A fixed divide-by-8 front end comes first. It is followed by an optional divide-by-154 stage, a power-of-two octave selector and four fractional rate stages. Each fractional stage either passes its input rate or scales it by a fixed ratio. The last enable stream toggles a flip-flop, and that flip-flop drives the tone pin.

Software programs the block through a small word-wide register bus with three registers: frequency, tone and general control. The frequency register is stored and read back only. Tone register bit 0 switches the tone on. Bits [1:0] of the same register also form the octave field, so with the tone on the octave code is always odd. General control bit 1 bypasses the divide-by-154 stage.

Top module: `buzz_tone`

## Requirements
- R1: The register at offset 0x00 is frequency, 0x04 is tone and 0x08 is general control. A read of any other offset returns zero. A write to any other offset changes no register.
- R2: Frequency keeps data bits [5:0], tone keeps bits [6:0] and general keeps bits [1:0]. All other bits read back as zero.
- R3: After reset all three registers read zero and the tone pin is low.
- R4: While tone bit 0 is clear, the tone pin stays low whatever the other bits hold.
- R5: The reference clock is divided by 8 before any other stage. With general bit 1 set, the octave code 1 and no fractional stage selected, the tone has a period of 64 clocks.
- R6: With general bit 1 clear, the rate is further divided by 154.
- R7: Tone bits [1:0] form an octave code n, and the rate is divided by 2<<n. Code 3 therefore gives a period four times that of code 1.
- R8: Tone bits 2, 3, 4 and 5 each select one fractional stage, with ratios 101/107, 49/55, 50/63 and 80/127 respectively. A clear bit passes the full rate. Each stage is an accumulator that never reaches its denominator, so a selected change takes effect without restarting any stage.
- R9: Each pulse leaving the last stage toggles the tone pin. The output frequency is therefore half the final pulse rate.
- R10: Only accesses with all four byte enables set take effect. A narrower write changes nothing, and a narrower read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (12 or 13 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the block window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tone_out | output | 1 | Square-wave buzzer output |

## Verification
The strobe assertions assume one thing about the block's inputs: the divide-by-8 front end limits every downstream pulse to at most one every eight clocks. Register changes therefore arrive between pulses and never inside a burst. The bench changes configuration only through complete bus writes. It lets each configuration settle before it counts rising edges over a fixed window. It compares that count with a rate computed from the divider ratios, allowing two edges of tolerance for the startup phase.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    localparam int NUM_FRAC  = 4;
    localparam int FRONT_DIV = 8;
    localparam int PRE_DIV   = 154;
    localparam int OCT_W     = 2;

    localparam logic [31:0] FREQ_MASK = 32'h0000_003F;
    localparam logic [31:0] TONE_MASK = 32'h0000_007F;
    localparam logic [31:0] GEN_MASK  = 32'h0000_0003;

    typedef enum logic [1:0] {
        SLOT_FREQ,
        SLOT_TONE,
        SLOT_GEN,
        SLOT_NONE
    } slot_e;

    typedef struct packed {
        logic                tone_on;
        logic [OCT_W-1:0]    octave;
        logic [NUM_FRAC-1:0] frac_sel;
        logic                pre_bypass;
    } buzz_cfg_t;

    function automatic int frac_num(input int idx);
        case (idx)
            0:       return 101;
            1:       return 49;
            2:       return 50;
            default: return 80;
        endcase
    endfunction

    function automatic int frac_den(input int idx);
        case (idx)
            0:       return 107;
            1:       return 55;
            2:       return 63;
            default: return 127;
        endcase
    endfunction

endpackage

// File: rtl/buzz_regs.sv
module buzz_regs
    import buzz_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output buzz_cfg_t         cfg
);

    logic [31:0] freq_q, tone_q, gen_q;
    slot_e       slot;
    logic        full;

    assign full = (be == 4'hF);

    always_comb begin
        if (addr == ADDR_W'(0))      slot = SLOT_FREQ;
        else if (addr == ADDR_W'(4)) slot = SLOT_TONE;
        else if (addr == ADDR_W'(8)) slot = SLOT_GEN;
        else                         slot = SLOT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
            tone_q <= '0;
            gen_q  <= '0;
        end else if (wr && full) begin
            case (slot)
                SLOT_FREQ: freq_q <= wdata & FREQ_MASK;
                SLOT_TONE: tone_q <= wdata & TONE_MASK;
                SLOT_GEN:  gen_q  <= wdata & GEN_MASK;
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (full) begin
            case (slot)
                SLOT_FREQ: rdata = freq_q;
                SLOT_TONE: rdata = tone_q;
                SLOT_GEN:  rdata = gen_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign cfg.tone_on    = tone_q[0];
    assign cfg.octave     = tone_q[OCT_W-1:0];
    assign cfg.frac_sel   = tone_q[2 +: NUM_FRAC];
    assign cfg.pre_bypass = gen_q[1];

    AST_NARROW_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && !full) |=> ($stable(freq_q) && $stable(tone_q) && $stable(gen_q))); // R10

endmodule

// File: rtl/buzz_prescale.sv
module buzz_prescale #(
    parameter int FRONT_DIV = 8,
    parameter int PRE_DIV   = 154
) (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    output logic front_stb,
    output logic pre_stb
);

    localparam int FW = $clog2(FRONT_DIV);
    localparam int PW = $clog2(PRE_DIV);

    logic [FW-1:0] front_cnt;
    logic [PW-1:0] pre_cnt;
    logic          pre_wrap;

    assign front_stb = (front_cnt == FW'(FRONT_DIV - 1));
    assign pre_wrap  = (pre_cnt >= PW'(PRE_DIV - 1));
    assign pre_stb   = front_stb && (bypass || pre_wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            front_cnt <= '0;
            pre_cnt   <= '0;
        end else begin
            front_cnt <= front_stb ? '0 : front_cnt + FW'(1);
            if (front_stb && !bypass)
                pre_cnt <= pre_wrap ? '0 : pre_cnt + PW'(1);
        end
    end

    AST_FRONT_SPACED: assert property (@(posedge clk) disable iff (rst)
        front_stb |=> !front_stb); // R5
    AST_PRE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        pre_stb |-> front_stb); // R6

endmodule

// File: rtl/buzz_octave.sv
module buzz_octave #(
    parameter int OCT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCT_W-1:0] octave,
    input  logic             in_stb,
    output logic             out_stb
);

    localparam int CW = (1 << OCT_W);

    logic [CW-1:0] cnt;
    logic [CW:0]   lim;
    logic          wrap;

    assign lim     = (CW + 1)'(2) << octave;
    assign wrap    = ({1'b0, cnt} >= (lim - (CW + 1)'(1)));
    assign out_stb = in_stb && wrap;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (in_stb)
            cnt <= wrap ? '0 : cnt + CW'(1);
    end

    AST_OCT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> in_stb); // R7

endmodule

// File: rtl/buzz_frac_stage.sv
module buzz_frac_stage #(
    parameter int NUM = 101,
    parameter int DEN = 107
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic in_stb,
    output logic out_stb
);

    localparam int AW = $clog2(NUM + DEN);

    logic [AW-1:0] acc, sum;
    logic          carry;

    assign sum     = acc + AW'(NUM);
    assign carry   = (sum >= AW'(DEN));
    assign out_stb = in_stb && (!sel || carry);

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (in_stb && sel)
            acc <= carry ? sum - AW'(DEN) : sum;
    end

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
        acc < AW'(DEN)); // R8
    AST_FRAC_SUBSET: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> in_stb); // R8

endmodule

// File: rtl/buzz_tone.sv
module buzz_tone
    import buzz_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tone_out
);

    buzz_cfg_t           cfg;
    logic                front_stb, pre_stb;
    logic [NUM_FRAC:0]   chain;
    logic                tgl_q;

    buzz_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .be    (bus_be),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    buzz_prescale #(.FRONT_DIV(FRONT_DIV), .PRE_DIV(PRE_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .bypass    (cfg.pre_bypass),
        .front_stb (front_stb),
        .pre_stb   (pre_stb)
    );

    buzz_octave #(.OCT_W(OCT_W)) u_oct (
        .clk     (clk),
        .rst     (rst),
        .octave  (cfg.octave),
        .in_stb  (pre_stb),
        .out_stb (chain[0])
    );

    for (genvar g = 0; g < NUM_FRAC; g++) begin : g_frac
        buzz_frac_stage #(.NUM(frac_num(g)), .DEN(frac_den(g))) u_stage (
            .clk     (clk),
            .rst     (rst),
            .sel     (cfg.frac_sel[g]),
            .in_stb  (chain[g]),
            .out_stb (chain[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.tone_on)
            tgl_q <= 1'b0;
        else if (chain[NUM_FRAC])
            tgl_q <= ~tgl_q;
    end

    assign tone_out = tgl_q;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg.tone_on |=> !tone_out); // R4
    AST_EDGE_PACED: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone_out) |-> ($past(chain[NUM_FRAC]) || !$past(cfg.tone_on))); // R9
    AST_SLOW_CHAIN: assert property (@(posedge clk) disable iff (rst)
        chain[NUM_FRAC] |-> front_stb); // R5

endmodule

// File: tb/buzz_tone_test.sv
module buzz_tone_test;

    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic [3:0]        bus_be;
    logic              bus_wr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic              tone_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    buzz_tone #(.ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tone_out  (tone_out)
    );

    always #4 clk = ~clk;

    // Each entry: general control, tone register, window length in clocks.
    localparam logic [28:0] VEC [0:5] = '{
        {2'd2, 7'h01, 20'd6400},
        {2'd2, 7'h03, 20'd6400},
        {2'd0, 7'h01, 20'd49280},
        {2'd2, 7'h05, 20'd6400},
        {2'd2, 7'h09, 20'd6400},
        {2'd2, 7'h3D, 20'd6400}
    };

    function automatic real expected_rises(input logic [1:0] gen, input logic [6:0] tone, input int win);
        real r;
        r = real'(win) / 8.0;
        if (!gen[1]) r = r / 154.0;
        r = r / real'(2 << tone[1:0]);
        if (tone[2]) r = r * 101.0 / 107.0;
        if (tone[3]) r = r * 49.0 / 55.0;
        if (tone[4]) r = r * 50.0 / 63.0;
        if (tone[5]) r = r * 80.0 / 127.0;
        return r / 2.0;
    endfunction

    function automatic string vec_tag(input int idx);
        case (idx)
            0:       return "R5 R9";
            1:       return "R7";
            2:       return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = 4'hF;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_be   = be;
        #1;
        d        = bus_rdata;
        bus_be   = 4'hF;
    endtask

    task automatic count_rises(input int win, output int n);
        logic prev;
        n    = 0;
        prev = tone_out;
        repeat (win) begin
            @(negedge clk);
            if (tone_out && !prev) n++;
            prev = tone_out;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                done = 1;
                checks++;
                errors++;
                $display("FAIL watchdog got %0d cycles expected completion", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        int          n;
        real         e;
        rst       = 1'b1;
        bus_addr  = '0;
        bus_be    = 4'hF;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R3 reset state
        bus_read(11'h000, 4'hF, d); check_eq("R3 freq reset", d, 32'h0);
        bus_read(11'h004, 4'hF, d); check_eq("R3 tone reset", d, 32'h0);
        bus_read(11'h008, 4'hF, d); check_eq("R3 gen reset", d, 32'h0);
        check_eq("R3 pin low", {31'b0, tone_out}, 32'h0);

        // R2 field masking
        bus_write(11'h000, 32'hFFFF_FFFF, 4'hF);
        bus_write(11'h004, 32'hFFFF_FF80, 4'hF);
        bus_write(11'h008, 32'hFFFF_FFFF, 4'hF);
        bus_read(11'h000, 4'hF, d); check_eq("R2 freq mask", d, 32'h3F);
        bus_read(11'h004, 4'hF, d); check_eq("R2 tone mask", d, 32'h0);
        bus_read(11'h008, 4'hF, d); check_eq("R2 gen mask", d, 32'h3);
        bus_write(11'h004, 32'hFFFF_FFFF, 4'hF);
        bus_read(11'h004, 4'hF, d); check_eq("R2 tone mask full", d, 32'h7F);
        bus_write(11'h004, 32'h0, 4'hF);

        // R1 unmapped offsets
        bus_write(11'h00C, 32'h0000_0015, 4'hF);
        bus_write(11'h001, 32'h0000_0000, 4'hF);
        bus_read(11'h00C, 4'hF, d); check_eq("R1 unmapped read", d, 32'h0);
        bus_read(11'h000, 4'hF, d); check_eq("R1 freq untouched", d, 32'h3F);

        // R10 narrow accesses
        bus_write(11'h000, 32'h0000_0005, 4'h1);
        bus_read(11'h000, 4'hF, d); check_eq("R10 narrow write ignored", d, 32'h3F);
        bus_read(11'h000, 4'h3, d); check_eq("R10 narrow read zero", d, 32'h0);

        // R4 tone disabled with all dividers selected
        bus_write(11'h008, 32'h2, 4'hF);
        bus_write(11'h004, 32'h3E, 4'hF);
        count_rises(2000, n);
        check_eq("R4 silent when off", n, 0);
        check_eq("R4 pin low", {31'b0, tone_out}, 32'h0);

        // Rate table
        for (int i = 0; i < 6; i++) begin
            bus_write(11'h008, {30'b0, VEC[i][28:27]}, 4'hF);
            bus_write(11'h004, {25'b0, VEC[i][26:20]}, 4'hF);
            repeat (5000) @(negedge clk);
            count_rises(int'(VEC[i][19:0]), n);
            e = expected_rises(VEC[i][28:27], VEC[i][26:20], int'(VEC[i][19:0]));
            checks++;
            if (real'(n) > e + 2.0 || real'(n) < e - 2.0) begin
                errors++;
                $display("FAIL %s case %0d got %0d rises expected %f", vec_tag(i), i, n, e);
            end
        end

        // R3 reset mid-tone returns to silence
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(11'h004, 4'hF, d); check_eq("R3 tone cleared by reset", d, 32'h0);
        count_rises(500, n);
        check_eq("R3 silent after reset", n, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule